// File: doc/BRIEF.md
# Memory Clear and Checkerboard Self-Test Sequencer

This block owns the housekeeping sweeps of a sample memory that sits beside a signal-processing core. On request it walks every address in ascending order and either writes zero into each word (a clear sweep) or writes an alternating two-word checkerboard and then reads every word back to compare it (a self-test). While a sweep runs it claims the memory port through `mem_own`, and the surrounding logic must hand the port over for that time.

Software reaches the block through one 32-bit control/status word. The word holds the clear request and the clear cancel, the test start and the pattern choice, a ready flag and a test verdict. It also holds two bits kept only for software: output mute and instruction direct mode. Two further bits serve the modulation oscillator: a sticky arithmetic-overflow flag, and a one-shot that clears that oscillator's state. A clear sweep that has started always runs to its last address unless the cancel bit stops it. A self-test can never be stopped. After a clear sweep completes, a word-clock holdoff must pass before another clear sweep may begin. Every reset queues a clear sweep, and so does each program change made while the part runs in internal mode.

Top module: `memsweep_ctrl`

## Requirements
- R1: While reset is held, the status word reads 0x00000088: mute (bit 7) and direct mode (bit 3) are 1 and every other bit is 0.
- R2: Each reset queues a clear sweep. The sweep starts on the first clock after reset. It writes 0 to addresses 0 through 2^ADDR_W-1 in ascending order, one per clock, while `mem_own` is high, and no read happens during it.
- R3: While the clear request (bit 6) is 1, clear sweeps repeat. Clearing bit 6 while a sweep runs does not shorten that sweep, and no new sweep follows it.
- R4: When the cancel bit (bit 5) is 1, a running clear sweep stops on the next clock. No clear sweep starts while bit 5 stays 1. A request still present when bit 5 drops is then served.
- R5: Between the end of one completed clear sweep and the start of the next, `mem_own` stays low for exactly HOLD_CYC+1 clocks.
- R6: A `prog_chg` pulse while `int_mode` is 1 starts a clear sweep two clocks later. While `int_mode` is 0, the pulse has no effect.
- R7: Writing 1 to bit 0 starts a self-test. The self-test writes every address, where an address whose bit 0 equals the pattern select bit (bit 1) gets 0x1555 and any other address gets 0x2AAA. It then reads every address back. Bit 0 reads 1 until the test ends and then clears itself. Writing 0 to bit 0 during the test does not stop the test.
- R8: The pass bit (bit 9) is cleared when a test starts. When the test ends, it is set only if every read-back word matched its expected value.
- R9: The ready bit (bit 8) is 1 only when no sweep runs, none is queued from reset or program change, and no test is pending.
- R10: The overflow flag (bit 10) is set by `ovf_in` and stays set. A status read (`cfg_re`) or a write with bit 4 set clears it. If a set and a clear arrive in the same clock, the set wins.
- R11: A write with bit 4 set gives a one-clock pulse on `lfo_clr` in the next clock. Bit 4 reads 1 only during that clock.
- R12: When a clear sweep is eligible to start, it wins over a pending self-test. A test requested during a clear sweep starts only after that sweep completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the control/status word |
| cfg_wdata | input | 32 | Control/status write data |
| cfg_re | input | 1 | Read strobe; clears the overflow flag |
| cfg_rdata | output | 32 | Current control/status word |
| ovf_in | input | 1 | Arithmetic overflow event |
| prog_chg | input | 1 | Program change pulse |
| int_mode | input | 1 | Internal (stand-alone) mode indicator |
| lfo_clr | output | 1 | One-clock oscillator state clear |
| mem_own | output | 1 | Sequencer holds the memory port |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read enable (data returns one clock later) |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data |

## Verification
The bench instantiates the block with ADDR_W = 4 and HOLD_CYC = 3, so one sweep covers only 16 words. At that size the bench can check every word of the memory model after each clear and each test, and it can measure sweep lengths and holdoff gaps exactly. The bench memory also has an injectable single-bit read fault at one address. With the fault enabled, a failing self-test is reached as easily as a passing one. The short sweeps also make it practical to aim a cancel, a request withdrawal or a test request at a clock in the middle of a sweep.

// File: rtl/msw_pkg.sv
package msw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ZERO = 3'd1,
        ST_TWR  = 3'd2,
        ST_TRD  = 3'd3,
        ST_TCHK = 3'd4
    } sweep_st_e;

    // status word bit positions (software decodes these)
    localparam int unsigned BIT_OVF  = 10;
    localparam int unsigned BIT_PASS = 9;
    localparam int unsigned BIT_RDY  = 8;
    localparam int unsigned BIT_MUTE = 7;
    localparam int unsigned BIT_ZREQ = 6;
    localparam int unsigned BIT_ZCAN = 5;
    localparam int unsigned BIT_LFO  = 4;
    localparam int unsigned BIT_DIR  = 3;
    localparam int unsigned BIT_PSEL = 1;
    localparam int unsigned BIT_GO   = 0;

    typedef struct packed {
        logic mute;
        logic zreq;
        logic zcan;
        logic lfo;
        logic dir;
        logic psel;
        logic go;
        logic ovf;
        logic pass;
        logic pend;
    } ctl_regs_t;

endpackage

// File: rtl/msw_addr_ctr.sv
module msw_addr_ctr #(
    parameter int unsigned ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              inc,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    logic [ADDR_W-1:0] addr_d, addr_q;

    always_comb begin
        addr_d = addr_q;
        if (clr)      addr_d = '0;
        else if (inc) addr_d = addr_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    assign addr = addr_q;
    assign last = (addr_q == {ADDR_W{1'b1}});

    // a clear always returns the walk to the first word
    assert_ctr_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (addr == '0));
endmodule

// File: rtl/msw_pattern.sv
module msw_pattern #(
    parameter int unsigned DATA_W = 14
) (
    input  logic              sel,
    input  logic              odd,
    output logic [DATA_W-1:0] word
);
    logic hi_sel;
    assign hi_sel = sel ^ odd;

    // hi_sel picks the word with odd bit positions set, otherwise even ones
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        if ((b % 2) == 1) begin : g_odd
            assign word[b] = hi_sel;
        end else begin : g_even
            assign word[b] = ~hi_sel;
        end
    end
endmodule

// File: rtl/msw_holdoff.sv
module msw_holdoff #(
    parameter int unsigned HOLD_CYC = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy
);
    localparam int unsigned HW = $clog2(HOLD_CYC + 1);
    localparam logic [HW-1:0] HOLD_VAL = HW'(HOLD_CYC);

    logic [HW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)               cnt_d = HOLD_VAL;
        else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);

    assert_hold_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> busy);
endmodule

// File: rtl/memsweep_ctrl.sv
module memsweep_ctrl
    import msw_pkg::*;
#(
    parameter int unsigned ADDR_W   = 10,
    parameter int unsigned DATA_W   = 14,
    parameter int unsigned HOLD_CYC = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [31:0]       cfg_wdata,
    input  logic              cfg_re,
    output logic [31:0]       cfg_rdata,
    input  logic              ovf_in,
    input  logic              prog_chg,
    input  logic              int_mode,
    output logic              lfo_clr,
    output logic              mem_own,
    output logic              mem_we,
    output logic              mem_re,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    typedef struct packed {
        sweep_st_e         st;
        ctl_regs_t         r;
        logic              psel_run;
        logic              cmp_v;
        logic [DATA_W-1:0] exp;
        logic              fail;
    } seq_t;

    seq_t cur_q, nxt_d;

    logic              ctr_clr, ctr_inc, ctr_last;
    logic [ADDR_W-1:0] ctr_addr;
    logic              hold_load, hold_busy;
    logic [DATA_W-1:0] pat_word;
    logic              zero_ok, mism;

    wire unused_wbits = ^{cfg_wdata[31:11], cfg_wdata[10:8], cfg_wdata[2]};

    msw_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (ctr_clr),
        .inc  (ctr_inc),
        .addr (ctr_addr),
        .last (ctr_last)
    );

    msw_holdoff #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk  (clk),
        .rst_n(rst_n),
        .load (hold_load),
        .busy (hold_busy)
    );

    msw_pattern #(.DATA_W(DATA_W)) u_pat (
        .sel (cur_q.psel_run),
        .odd (ctr_addr[0]),
        .word(pat_word)
    );

    assign zero_ok = (cur_q.r.zreq || cur_q.r.pend) && !cur_q.r.zcan && !hold_busy;
    assign mism    = cur_q.cmp_v && (mem_rdata != cur_q.exp);

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.r.lfo = 1'b0;
        ctr_clr   = 1'b0;
        ctr_inc   = 1'b0;
        hold_load = 1'b0;

        if (cfg_we) begin
            nxt_d.r.mute = cfg_wdata[BIT_MUTE];
            nxt_d.r.zreq = cfg_wdata[BIT_ZREQ];
            nxt_d.r.zcan = cfg_wdata[BIT_ZCAN];
            nxt_d.r.dir  = cfg_wdata[BIT_DIR];
            nxt_d.r.psel = cfg_wdata[BIT_PSEL];
            nxt_d.r.lfo  = cfg_wdata[BIT_LFO];
            nxt_d.r.go   = cur_q.r.go | cfg_wdata[BIT_GO];
        end

        if (cfg_re || (cfg_we && cfg_wdata[BIT_LFO])) nxt_d.r.ovf = 1'b0;
        if (ovf_in)                                   nxt_d.r.ovf = 1'b1;

        if ((cur_q.st == ST_TRD || cur_q.st == ST_TCHK) && mism) nxt_d.fail = 1'b1;

        unique case (cur_q.st)
            ST_IDLE: begin
                if (zero_ok) begin
                    nxt_d.st     = ST_ZERO;
                    nxt_d.r.pend = 1'b0;
                end else if (cur_q.r.go) begin
                    nxt_d.st       = ST_TWR;
                    nxt_d.r.pass   = 1'b0;
                    nxt_d.psel_run = cur_q.r.psel;
                    nxt_d.fail     = 1'b0;
                end
            end
            ST_ZERO: begin
                if (cur_q.r.zcan) begin
                    nxt_d.st = ST_IDLE;
                    ctr_clr  = 1'b1;
                end else begin
                    ctr_inc = 1'b1;
                    if (ctr_last) begin
                        nxt_d.st  = ST_IDLE;
                        hold_load = 1'b1;
                    end
                end
            end
            ST_TWR: begin
                ctr_inc = 1'b1;
                if (ctr_last) nxt_d.st = ST_TRD;
            end
            ST_TRD: begin
                ctr_inc     = 1'b1;
                nxt_d.cmp_v = 1'b1;
                nxt_d.exp   = pat_word;
                if (ctr_last) nxt_d.st = ST_TCHK;
            end
            ST_TCHK: begin
                nxt_d.st     = ST_IDLE;
                nxt_d.cmp_v  = 1'b0;
                nxt_d.r.go   = 1'b0;
                nxt_d.r.pass = !(cur_q.fail || mism);
            end
            default: nxt_d.st = ST_IDLE;
        endcase

        if (prog_chg && int_mode) nxt_d.r.pend = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q        <= '0;
            cur_q.r.mute <= 1'b1;
            cur_q.r.dir  <= 1'b1;
            cur_q.r.pend <= 1'b1;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign mem_own   = (cur_q.st != ST_IDLE);
    assign mem_we    = ((cur_q.st == ST_ZERO) && !cur_q.r.zcan) || (cur_q.st == ST_TWR);
    assign mem_re    = (cur_q.st == ST_TRD);
    assign mem_addr  = ctr_addr;
    assign mem_wdata = (cur_q.st == ST_TWR) ? pat_word : '0;
    assign lfo_clr   = cur_q.r.lfo;

    always_comb begin
        cfg_rdata           = '0;
        cfg_rdata[BIT_OVF]  = cur_q.r.ovf;
        cfg_rdata[BIT_PASS] = cur_q.r.pass;
        cfg_rdata[BIT_RDY]  = (cur_q.st == ST_IDLE) && !cur_q.r.go && !cur_q.r.pend;
        cfg_rdata[BIT_MUTE] = cur_q.r.mute;
        cfg_rdata[BIT_ZREQ] = cur_q.r.zreq;
        cfg_rdata[BIT_ZCAN] = cur_q.r.zcan;
        cfg_rdata[BIT_LFO]  = cur_q.r.lfo;
        cfg_rdata[BIT_DIR]  = cur_q.r.dir;
        cfg_rdata[BIT_PSEL] = cur_q.r.psel;
        cfg_rdata[BIT_GO]   = cur_q.r.go;
    end

    // ---------------- assertions ----------------
    assert_port_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_we, mem_re}) && (mem_own || !(mem_we || mem_re)));

    assert_zero_cancel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.r.zcan |=> (cur_q.st != ST_ZERO));

    assert_holdoff_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_IDLE && hold_busy) |=> (cur_q.st != ST_ZERO));

    assert_test_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_TWR || cur_q.st == ST_TRD || cur_q.st == ST_TCHK) |-> cur_q.r.go);

    assert_pass_update_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cur_q.r.pass) |-> ($past(cur_q.st) == ST_TCHK));

    assert_lfo_ovf_R11: assert property (@(posedge clk) disable iff (!rst_n)
        lfo_clr |-> (!cur_q.r.ovf || $past(ovf_in)));
endmodule

// File: tb/tb_memsweep_ctrl.sv
module tb_memsweep_ctrl;
    localparam int unsigned AW    = 4;
    localparam int unsigned DW    = 14;
    localparam int unsigned HOLD  = 3;
    localparam int unsigned DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0, cfg_re = 1'b0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_rdata;
    logic          ovf_in = 1'b0, prog_chg = 1'b0, int_mode = 1'b0;
    logic          lfo_clr, mem_own, mem_we, mem_re;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;

    logic [DW-1:0] mem [DEPTH];
    logic          fault_en = 1'b0;
    int            run_cnt = 0, last_run = 0;
    int            n_chk = 0, n_err = 0;
    bit            sh_mute = 1, sh_z = 0, sh_x = 0, sh_dir = 1, sh_psel = 0;

    always #10 clk = ~clk;  // 50 MHz

    memsweep_ctrl #(.ADDR_W(AW), .DATA_W(DW), .HOLD_CYC(HOLD)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_re(cfg_re), .cfg_rdata(cfg_rdata), .ovf_in(ovf_in),
        .prog_chg(prog_chg), .int_mode(int_mode), .lfo_clr(lfo_clr),
        .mem_own(mem_own), .mem_we(mem_we), .mem_re(mem_re),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // memory model with one-clock read latency and an injectable read fault at word 5
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        if (mem_re) mem_rdata <= mem[mem_addr] ^ ((fault_en && mem_addr == AW'(5)) ? DW'(1) : DW'(0));
        if (mem_we) run_cnt <= run_cnt + 1;
        else if (run_cnt != 0) begin
            last_run <= run_cnt;
            run_cnt  <= 0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(input bit psel, input int a);
        return (psel == a[0]) ? 14'h1555 : 14'h2AAA;
    endfunction

    task automatic wr_ctl(input bit go, input bit l);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = '0;
        cfg_wdata[7] = sh_mute; cfg_wdata[6] = sh_z; cfg_wdata[5] = sh_x;
        cfg_wdata[4] = l; cfg_wdata[3] = sh_dir; cfg_wdata[1] = sh_psel; cfg_wdata[0] = go;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_ready(input string req);
        int n = 0;
        while (!(cfg_rdata[8] && !mem_own) && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk(n < 2000, req, n, 0);
    endtask

    task automatic settle();
        repeat (HOLD + 3) @(negedge clk);
    endtask

    task automatic t_reset();
        for (int a = 0; a < DEPTH; a++) mem[a] = 14'h3FFF;
        repeat (3) @(negedge clk);
        chk(cfg_rdata == 32'h88, "R1 reset word", cfg_rdata, 32'h88);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_own == 1'b1, "R2 sweep after reset", mem_own, 1);
        chk(cfg_rdata[8] == 1'b0, "R9 not ready while clearing", cfg_rdata[8], 0);
        wait_ready("R2 reset sweep ends");
        @(negedge clk);
        chk(last_run == DEPTH, "R2 sweep length", last_run, DEPTH);
        for (int a = 0; a < DEPTH; a++)
            chk(mem[a] == '0, "R2 word cleared", mem[a], 0);
        chk(cfg_rdata == 32'h188, "R9 ready when idle", cfg_rdata, 32'h188);
    endtask

    task automatic t_zreq_drop();
        settle();
        sh_z = 1; wr_ctl(0, 0);
        while (!mem_own) @(negedge clk);
        sh_z = 0; wr_ctl(0, 0);
        chk(mem_own == 1'b1, "R3 sweep continues after request drop", mem_own, 1);
        while (mem_own) @(negedge clk);
        @(negedge clk);
        chk(last_run == DEPTH, "R3 full sweep length", last_run, DEPTH);
        begin
            bit seen = 0;
            repeat (HOLD + 6) begin
                @(negedge clk);
                if (mem_own) seen = 1;
            end
            chk(!seen, "R3 no restart after drop", seen, 0);
        end
    endtask

    task automatic t_holdoff();
        int gap = 0;
        settle();
        sh_z = 1; wr_ctl(0, 0);
        while (!mem_own) @(negedge clk);
        while (mem_own) @(negedge clk);
        while (!mem_own) begin
            gap++;
            @(negedge clk);
        end
        chk(gap == HOLD + 1, "R5 holdoff gap", gap, HOLD + 1);
        sh_z = 0; wr_ctl(0, 0);
        wait_ready("R5 back to idle");
    endtask

    task automatic t_cancel();
        bit seen = 0;
        settle();
        sh_z = 1; wr_ctl(0, 0);
        while (!mem_own) @(negedge clk);
        @(negedge clk);
        sh_x = 1; wr_ctl(0, 0);
        @(negedge clk);
        chk(mem_own == 1'b0, "R4 cancel stops sweep", mem_own, 0);
        @(negedge clk);
        chk(last_run < DEPTH, "R4 aborted sweep shorter", last_run, DEPTH - 1);
        repeat (HOLD + 8) begin
            @(negedge clk);
            if (mem_own) seen = 1;
        end
        chk(!seen, "R4 cancel blocks request", seen, 0);
        sh_x = 0; wr_ctl(0, 0);
        repeat (2) @(negedge clk);
        chk(mem_own == 1'b1, "R4 request served after cancel drops", mem_own, 1);
        sh_z = 0; wr_ctl(0, 0);
        wait_ready("R4 idle");
    endtask

    task automatic t_prog();
        bit seen = 0;
        settle();
        int_mode = 1'b0;
        @(negedge clk); prog_chg = 1'b1;
        @(negedge clk); prog_chg = 1'b0;
        repeat (HOLD + 4) begin
            @(negedge clk);
            if (mem_own) seen = 1;
        end
        chk(!seen, "R6 change ignored outside internal mode", seen, 0);
        int_mode = 1'b1;
        @(negedge clk); prog_chg = 1'b1;
        @(negedge clk); prog_chg = 1'b0;
        @(negedge clk);
        chk(mem_own == 1'b1, "R6 change starts sweep", mem_own, 1);
        int_mode = 1'b0;
    endtask

    // entered while the sweep from t_prog runs
    task automatic t_test_during_zero();
        sh_psel = 1; wr_ctl(1, 0);
        chk(cfg_rdata[0] == 1'b1, "R12 test request held", cfg_rdata[0], 1);
        chk(cfg_rdata[8] == 1'b0, "R12 not ready with test queued", cfg_rdata[8], 0);
        wait_ready("R12 test completes");
        for (int a = 0; a < DEPTH; a++)
            chk(mem[a] == pat(1, a), "R7 pattern select 1", mem[a], pat(1, a));
        chk(cfg_rdata[9] == 1'b1, "R8 pass on clean memory", cfg_rdata[9], 1);
        chk(cfg_rdata[0] == 1'b0, "R7 start bit self-clears", cfg_rdata[0], 0);
    endtask

    task automatic t_test_fail();
        fault_en = 1'b1;
        wr_ctl(1, 0);
        @(negedge clk);
        chk(cfg_rdata[9] == 1'b0, "R8 pass cleared at start", cfg_rdata[9], 0);
        wait_ready("R8 faulty test ends");
        chk(cfg_rdata[9] == 1'b0, "R8 fail on mismatch", cfg_rdata[9], 0);
        fault_en = 1'b0;
    endtask

    task automatic t_test_nocancel();
        sh_psel = 0; wr_ctl(1, 0);
        repeat (3) @(negedge clk);
        wr_ctl(0, 0);
        chk(cfg_rdata[0] == 1'b1 && mem_own, "R7 test not cancelled", cfg_rdata[0], 1);
        wait_ready("R7 test ends");
        for (int a = 0; a < DEPTH; a++)
            chk(mem[a] == pat(0, a), "R7 pattern select 0", mem[a], pat(0, a));
        chk(cfg_rdata[9] == 1'b1, "R8 pass after uncancelled test", cfg_rdata[9], 1);
    endtask

    task automatic t_ovf();
        @(negedge clk); ovf_in = 1'b1;
        @(negedge clk); ovf_in = 1'b0;
        chk(cfg_rdata[10] == 1'b1, "R10 overflow set", cfg_rdata[10], 1);
        @(negedge clk);
        chk(cfg_rdata[10] == 1'b1, "R10 overflow sticky", cfg_rdata[10], 1);
        ovf_in = 1'b1; cfg_re = 1'b1;
        @(negedge clk); ovf_in = 1'b0; cfg_re = 1'b0;
        chk(cfg_rdata[10] == 1'b1, "R10 set wins over read", cfg_rdata[10], 1);
        cfg_re = 1'b1;
        @(negedge clk); cfg_re = 1'b0;
        chk(cfg_rdata[10] == 1'b0, "R10 read clears", cfg_rdata[10], 0);
    endtask

    task automatic t_lfo();
        @(negedge clk); ovf_in = 1'b1;
        @(negedge clk); ovf_in = 1'b0;
        chk(lfo_clr == 1'b0, "R11 no pulse before write", lfo_clr, 0);
        wr_ctl(0, 1);
        chk(lfo_clr == 1'b1 && cfg_rdata[4], "R11 pulse after write", lfo_clr, 1);
        chk(cfg_rdata[10] == 1'b0, "R10 oscillator clear clears overflow", cfg_rdata[10], 0);
        @(negedge clk);
        chk(lfo_clr == 1'b0 && !cfg_rdata[4], "R11 pulse one clock", lfo_clr, 0);
    endtask

    bit done = 0;

    initial begin
        t_reset();
        t_zreq_drop();
        t_holdoff();
        t_cancel();
        t_prog();
        t_test_during_zero();
        t_test_fail();
        t_test_nocancel();
        t_ovf();
        t_lfo();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule